// File: doc/BRIEF.md
# Video RAM Fill and Copy DMA Engine

This block carries out the two transfers a tile-based video controller performs entirely inside its own 64 KB byte-addressed video memory. In fill mode the engine waits for a data word, writes it as an ordinary word, and then repeats its upper byte across a run of addresses. In copy mode it moves a run of bytes from one video memory address to another. The engine reaches the memory through one single-port byte interface with synchronous reads.

A start pulse loads the mode, destination address, address step, 16-bit transfer count and 16-bit source address. A transfer-enable input lets an external rate limiter pace the engine: no memory access is made in a cycle where it is low. When the run ends, the engine pulses a done flag. The remaining count, the final source address and the final destination address are then held on outputs for the register file to write back. A busy flag stays high while memory traffic is in progress.

Top module: `vdma_engine`

## Requirements
- R1: After reset, busy_o, fill_armed_o, done_o and ram_we_o are all 0, and len_o, src_o and dst_o are 0.
- R2: A loaded count of 0 runs 65536 steps. A fill with count 0 keeps busy_o high for exactly 65538 cycles when xfer_en_i stays high: 2 word-write cycles plus 65536 fill cycles.
- R3: Copy (mode_copy_i=1) reads the byte at the source address and writes it to the destination address on each step. The source then advances by 1 and the destination by incr_i. Both addresses wrap within 16 bits.
- R4: Copy steps run strictly in order, with each step's read before its write. A byte written by one step is the byte a later step reads from that address, so a destination one above the source replicates the first byte.
- R5: A fill start (mode_copy_i=0) sets fill_armed_o one cycle later. While armed, busy_o stays 0 and no memory write is made. The data_wr_i that follows clears fill_armed_o and starts the fill. data_wr_i has no effect when the engine is not armed.
- R6: The fill word first goes through a normal word write. With an even destination, data_i[7:0] goes to the even byte and data_i[15:8] to the odd byte. With an odd destination the two bytes are swapped. The destination then advances by incr_i.
- R7: Each fill step writes data_i[15:8] to the current destination with address bit 0 inverted, then advances the destination by incr_i.
- R8: done_o is a one-cycle pulse that comes in the cycle after the final step. At that point len_o is 0, src_o holds the final source address and dst_o holds the final destination address.
- R9: busy_o rises in the cycle after a copy start or after the arming data_wr_i, and it is 0 when done_o is high.
- R10: While xfer_en_i is 0, ram_we_o is 0 and neither the count nor the addresses change. The transfer resumes when xfer_en_i returns to 1, and the results are the same as in an unstalled run.
- R11: A start_i that arrives while busy_o or fill_armed_o is high is ignored. The transfer in progress and its results are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; loads the inputs below |
| mode_copy_i | input | 1 | 1 = copy, 0 = fill |
| dst_i | input | 16 | Starting destination address |
| incr_i | input | 8 | Destination step per transfer |
| len_i | input | 16 | Transfer count, 0 means 65536 |
| src_i | input | 16 | Starting copy source address |
| data_wr_i | input | 1 | Data-port write strobe that triggers an armed fill |
| data_i | input | 16 | Fill data word |
| xfer_en_i | input | 1 | Allows a memory access in this cycle |
| ram_addr_o | output | 16 | Memory byte address |
| ram_we_o | output | 1 | Memory write enable |
| ram_wdata_o | output | 8 | Memory write byte |
| ram_rdata_i | input | 8 | Memory read byte, valid one cycle after its address |
| busy_o | output | 1 | Transfer in progress |
| fill_armed_o | output | 1 | Fill waiting for its data word |
| done_o | output | 1 | One-cycle completion pulse |
| len_o | output | 16 | Remaining count for write-back |
| src_o | output | 16 | Current or final source address |
| dst_o | output | 16 | Current or final destination address |

## Verification
Two events can land in the same cycle: a stall from the rate limiter and the copy's read-to-write hand-off. If xfer_en_i drops just after a read, the engine must keep presenting the source address so that the byte it later writes is still the right one. The bench provokes this by toggling xfer_en_i in a fixed pattern during a copy. It then judges the run by the destination bytes, which must match an unstalled copy, and by ram_we_o, which must stay low in every stalled cycle. A second collision is a start pulse that arrives while a transfer is running or a fill is armed. The bench judges that case by the final memory contents and by fill_armed_o.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_WLO,
        ST_WHI,
        ST_FILL,
        ST_CRD,
        ST_CWR
    } vdma_state_e;

endpackage

// File: rtl/vdma_len_decode.sv
module vdma_len_decode #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] len_i,
    output logic [AW:0]   count_o
);
    localparam logic [AW:0] FULL_RUN = {1'b1, {AW{1'b0}}};

    always_comb begin
        if (len_i == '0) count_o = FULL_RUN;
        else             count_o = {1'b0, len_i};
    end
endmodule

// File: rtl/vdma_addr_step.sv
module vdma_addr_step #(
    parameter int AW = 16,
    parameter int IW = 8
) (
    input  logic [AW-1:0] dst_i,
    input  logic [AW-1:0] src_i,
    input  logic [IW-1:0] incr_i,
    output logic [AW-1:0] dst_next_o,
    output logic [AW-1:0] src_next_o
);
    localparam int PADW = AW - IW;

    logic [AW-1:0] incr_ext;

    generate
        if (PADW > 0) begin : g_pad
            assign incr_ext = {{PADW{1'b0}}, incr_i};
        end else begin : g_nopad
            assign incr_ext = incr_i[AW-1:0];
        end
    endgenerate

    assign dst_next_o = dst_i + incr_ext;
    assign src_next_o = src_i + {{(AW-1){1'b0}}, 1'b1};
endmodule

// File: rtl/vdma_port_mux.sv
module vdma_port_mux
    import vdma_pkg::*;
#(
    parameter int AW = 16
) (
    input  vdma_state_e   st_i,
    input  logic [AW-1:0] dst_i,
    input  logic [AW-1:0] src_i,
    input  logic [15:0]   word_i,
    input  logic [7:0]    rdata_i,
    input  logic          en_i,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output logic [7:0]    wdata_o
);
    logic [7:0] byte_even;
    logic [7:0] byte_odd;

    always_comb begin
        byte_even = dst_i[0] ? word_i[15:8] : word_i[7:0];
        byte_odd  = dst_i[0] ? word_i[7:0]  : word_i[15:8];
        addr_o    = dst_i;
        we_o      = 1'b0;
        wdata_o   = 8'h00;
        unique case (st_i)
            ST_WLO: begin
                addr_o  = {dst_i[AW-1:1], 1'b0};
                we_o    = en_i;
                wdata_o = byte_even;
            end
            ST_WHI: begin
                addr_o  = {dst_i[AW-1:1], 1'b1};
                we_o    = en_i;
                wdata_o = byte_odd;
            end
            ST_FILL: begin
                addr_o  = {dst_i[AW-1:1], ~dst_i[0]};
                we_o    = en_i;
                wdata_o = word_i[15:8];
            end
            ST_CRD: begin
                addr_o = src_i;
            end
            ST_CWR: begin
                addr_o  = en_i ? dst_i : src_i;
                we_o    = en_i;
                wdata_o = rdata_i;
            end
            default: begin
                addr_o = dst_i;
            end
        endcase
    end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_copy_i,
    input  logic [AW-1:0] dst_i,
    input  logic [IW-1:0] incr_i,
    input  logic [AW-1:0] len_i,
    input  logic [AW-1:0] src_i,
    input  logic          data_wr_i,
    input  logic [15:0]   data_i,
    input  logic          xfer_en_i,
    output logic [AW-1:0] ram_addr_o,
    output logic          ram_we_o,
    output logic [7:0]    ram_wdata_o,
    input  logic [7:0]    ram_rdata_i,
    output logic          busy_o,
    output logic          fill_armed_o,
    output logic          done_o,
    output logic [AW-1:0] len_o,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] LAST_STEP = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        vdma_state_e   st;
        logic [AW-1:0] dst;
        logic [AW-1:0] src;
        logic [IW-1:0] incr;
        logic [CW-1:0] cnt;
        logic [15:0]   word;
        logic          done;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [CW-1:0] load_cnt;
    logic [AW-1:0] dst_next;
    logic [AW-1:0] src_next;

    vdma_len_decode #(.AW(AW)) len_dec_i (
        .len_i   (len_i),
        .count_o (load_cnt)
    );

    vdma_addr_step #(.AW(AW), .IW(IW)) step_i (
        .dst_i      (ctx_q.dst),
        .src_i      (ctx_q.src),
        .incr_i     (ctx_q.incr),
        .dst_next_o (dst_next),
        .src_next_o (src_next)
    );

    vdma_port_mux #(.AW(AW)) port_i (
        .st_i    (ctx_q.st),
        .dst_i   (ctx_q.dst),
        .src_i   (ctx_q.src),
        .word_i  (ctx_q.word),
        .rdata_i (ram_rdata_i),
        .en_i    (xfer_en_i),
        .addr_o  (ram_addr_o),
        .we_o    (ram_we_o),
        .wdata_o (ram_wdata_o)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctx_d.dst  = dst_i;
                    ctx_d.src  = src_i;
                    ctx_d.incr = incr_i;
                    ctx_d.cnt  = load_cnt;
                    ctx_d.st   = mode_copy_i ? ST_CRD : ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (data_wr_i) begin
                    ctx_d.word = data_i;
                    ctx_d.st   = ST_WLO;
                end
            end
            ST_WLO: begin
                if (xfer_en_i) ctx_d.st = ST_WHI;
            end
            ST_WHI: begin
                if (xfer_en_i) begin
                    ctx_d.dst = dst_next;
                    ctx_d.st  = ST_FILL;
                end
            end
            ST_FILL: begin
                if (xfer_en_i) begin
                    ctx_d.dst = dst_next;
                    ctx_d.cnt = ctx_q.cnt - LAST_STEP;
                    if (ctx_q.cnt == LAST_STEP) begin
                        ctx_d.st   = ST_IDLE;
                        ctx_d.done = 1'b1;
                    end
                end
            end
            ST_CRD: begin
                if (xfer_en_i) ctx_d.st = ST_CWR;
            end
            ST_CWR: begin
                if (xfer_en_i) begin
                    ctx_d.dst = dst_next;
                    ctx_d.src = src_next;
                    ctx_d.cnt = ctx_q.cnt - LAST_STEP;
                    if (ctx_q.cnt == LAST_STEP) begin
                        ctx_d.st   = ST_IDLE;
                        ctx_d.done = 1'b1;
                    end else begin
                        ctx_d.st = ST_CRD;
                    end
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy_o       = (ctx_q.st != ST_IDLE) && (ctx_q.st != ST_ARMED);
    assign fill_armed_o = (ctx_q.st == ST_ARMED);
    assign done_o       = ctx_q.done;
    assign len_o        = ctx_q.cnt[AW-1:0];
    assign src_o        = ctx_q.src;
    assign dst_o        = ctx_q.dst;
endmodule

// File: rtl/vdma_engine_chk.sv
module vdma_engine_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          xfer_en_i,
    input logic          ram_we_o,
    input logic          busy_o,
    input logic          fill_armed_o,
    input logic          done_o,
    input logic [AW-1:0] len_o,
    input logic [AW-1:0] dst_o
);
    // R10: a stalled cycle never writes memory
    a_r10_no_write_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en_i |-> !ram_we_o);

    // R10: a stalled busy cycle freezes count and destination
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !xfer_en_i) |=> ($stable(len_o) && $stable(dst_o)));

    // R9: memory writes happen only while busy
    a_r9_write_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> busy_o);

    // R8: done follows a busy cycle, with busy dropped and count drained
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o && (len_o == '0)));

    // R5: armed and busy are exclusive
    a_r5_armed_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fill_armed_o |-> !busy_o);

    // R11: a start during a transfer cannot arm a fill
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !fill_armed_o);
endmodule

bind vdma_engine vdma_engine_chk #(.AW(AW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .xfer_en_i    (xfer_en_i),
    .ram_we_o     (ram_we_o),
    .busy_o       (busy_o),
    .fill_armed_o (fill_armed_o),
    .done_o       (done_o),
    .len_o        (len_o),
    .dst_o        (dst_o)
);

// File: tb/vdma_engine_tb_top.sv
module vdma_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_copy_i = 1'b0;
    logic [15:0] dst_i = '0;
    logic [7:0]  incr_i = '0;
    logic [15:0] len_i = '0;
    logic [15:0] src_i = '0;
    logic        data_wr_i = 1'b0;
    logic [15:0] data_i = '0;
    logic        xfer_en_i = 1'b1;
    logic [15:0] ram_addr_o;
    logic        ram_we_o;
    logic [7:0]  ram_wdata_o;
    logic [7:0]  ram_rdata_i;
    logic        busy_o, fill_armed_o, done_o;
    logic [15:0] len_o, src_o, dst_o;

    logic [7:0]    mem [0:(1<<MW)-1];
    logic          pl_we = 1'b0;
    logic [15:0]   pl_addr = '0;
    logic [7:0]    pl_data = '0;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (pl_we)         mem[pl_addr[MW-1:0]] <= pl_data;
        else if (ram_we_o) mem[ram_addr_o[MW-1:0]] <= ram_wdata_o;
        ram_rdata_i <= mem[ram_addr_o[MW-1:0]];
    end

    vdma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_copy_i(mode_copy_i),
        .dst_i(dst_i), .incr_i(incr_i), .len_i(len_i), .src_i(src_i),
        .data_wr_i(data_wr_i), .data_i(data_i), .xfer_en_i(xfer_en_i),
        .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o), .ram_wdata_o(ram_wdata_o),
        .ram_rdata_i(ram_rdata_i), .busy_o(busy_o), .fill_armed_o(fill_armed_o),
        .done_o(done_o), .len_o(len_o), .src_o(src_o), .dst_o(dst_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    function automatic logic [7:0] peek(input logic [15:0] a);
        return mem[a[MW-1:0]];
    endfunction

    task automatic kick(input logic cp, input logic [15:0] d, input logic [7:0] inc,
                        input logic [15:0] n, input logic [15:0] s);
        @(negedge clk);
        start_i = 1'b1; mode_copy_i = cp; dst_i = d; incr_i = inc; len_i = n; src_i = s;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic data_write(input logic [15:0] w);
        @(negedge clk);
        data_wr_i = 1'b1; data_i = w;
        @(negedge clk);
        data_wr_i = 1'b0;
    endtask

    task automatic wait_done(output int busy_cycles);
        busy_cycles = 0;
        for (int i = 0; i < 140000; i++) begin
            if (done_o) break;
            if (busy_o) busy_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(!busy_o && !fill_armed_o && !done_o && !ram_we_o, "R1 flags", {busy_o, fill_armed_o, done_o, ram_we_o}, 0);
        chk(len_o == 0 && src_o == 0 && dst_o == 0, "R1 outputs", len_o ^ src_o ^ dst_o, 0);
    endtask

    task automatic t_copy_basic();
        int bc;
        for (int i = 0; i < 4; i++) poke(16'h0200 + 16'(i), 8'hA0 + 8'(i));
        kick(1'b1, 16'h0300, 8'd2, 16'd4, 16'h0200);
        chk(busy_o, "R9 busy after copy start", busy_o, 1);
        wait_done(bc);
        for (int i = 0; i < 4; i++)
            chk(peek(16'h0300 + 16'(2*i)) == 8'hA0 + 8'(i), "R3 copy byte", peek(16'h0300 + 16'(2*i)), 8'hA0 + i);
        chk(done_o && !busy_o, "R9 busy low at done", busy_o, 0);
        chk(len_o == 0 && src_o == 16'h0204 && dst_o == 16'h0308, "R8 writeback", src_o, 16'h0204);
        @(negedge clk);
        chk(!done_o, "R8 done single pulse", done_o, 0);
    endtask

    task automatic t_copy_overlap();
        int bc;
        poke(16'h0400, 8'h5A);
        for (int i = 1; i < 5; i++) poke(16'h0400 + 16'(i), 8'h00);
        kick(1'b1, 16'h0401, 8'd1, 16'd3, 16'h0400);
        wait_done(bc);
        for (int i = 1; i < 4; i++)
            chk(peek(16'h0400 + 16'(i)) == 8'h5A, "R4 ordered replicate", peek(16'h0400 + 16'(i)), 8'h5A);
        chk(peek(16'h0404) == 8'h00, "R4 stops at length", peek(16'h0404), 0);
    endtask

    task automatic t_copy_wrap();
        int bc;
        poke(16'hFFFF, 8'h11);
        poke(16'h0000, 8'h22);
        kick(1'b1, 16'hFFFE, 8'd3, 16'd2, 16'hFFFF);
        wait_done(bc);
        chk(peek(16'hFFFE) == 8'h11, "R3 wrap first", peek(16'hFFFE), 8'h11);
        chk(peek(16'h0001) == 8'h22, "R3 wrap second", peek(16'h0001), 8'h22);
        chk(src_o == 16'h0001 && dst_o == 16'h0004, "R8 wrapped writeback", {src_o, dst_o}, 32'h00010004);
    endtask

    task automatic t_fill_even();
        int bc;
        int wr_seen = 0;
        for (int i = 0; i < 9; i++) poke(16'h0800 + 16'(i), 8'h77);
        kick(1'b0, 16'h0800, 8'd2, 16'd3, 16'h0000);
        chk(fill_armed_o && !busy_o, "R5 armed not busy", {fill_armed_o, busy_o}, 2);
        for (int i = 0; i < 5; i++) begin
            if (ram_we_o) wr_seen++;
            @(negedge clk);
        end
        chk(wr_seen == 0, "R5 no write while armed", wr_seen, 0);
        data_write(16'hBEEF);
        chk(busy_o && !fill_armed_o, "R5 armed cleared by data", {busy_o, fill_armed_o}, 2);
        wait_done(bc);
        chk(peek(16'h0800) == 8'hEF && peek(16'h0801) == 8'hBE, "R6 even word", {peek(16'h0800), peek(16'h0801)}, 16'hEFBE);
        chk(peek(16'h0803) == 8'hBE && peek(16'h0805) == 8'hBE && peek(16'h0807) == 8'hBE,
            "R7 fill bytes", peek(16'h0807), 8'hBE);
        chk(peek(16'h0802) == 8'h77 && peek(16'h0804) == 8'h77 && peek(16'h0806) == 8'h77 && peek(16'h0808) == 8'h77,
            "R7 untouched gaps", peek(16'h0808), 8'h77);
        chk(dst_o == 16'h0808 && len_o == 0 && !fill_armed_o, "R8 fill writeback", dst_o, 16'h0808);
    endtask

    task automatic t_fill_odd();
        int bc;
        for (int i = 0; i < 4; i++) poke(16'h0900 + 16'(i), 8'h77);
        kick(1'b0, 16'h0901, 8'd2, 16'd1, 16'h0000);
        data_write(16'h1234);
        wait_done(bc);
        chk(peek(16'h0900) == 8'h12 && peek(16'h0901) == 8'h34, "R6 odd swapped word", {peek(16'h0900), peek(16'h0901)}, 16'h1234);
        chk(peek(16'h0902) == 8'h12, "R7 inverted bit0", peek(16'h0902), 8'h12);
        chk(peek(16'h0903) == 8'h77, "R7 odd target untouched", peek(16'h0903), 8'h77);
        chk(dst_o == 16'h0905, "R8 odd fill dst", dst_o, 16'h0905);
    endtask

    task automatic t_stall();
        int stalled_writes = 0;
        int n = 0;
        for (int i = 0; i < 6; i++) poke(16'h0600 + 16'(i), 8'h30 + 8'(i));
        kick(1'b1, 16'h0700, 8'd1, 16'd6, 16'h0600);
        for (int i = 0; i < 400; i++) begin
            if (done_o) break;
            xfer_en_i = ((n % 3) != 1) && ((n % 7) != 4);
            n++;
            #1;
            if (!xfer_en_i && ram_we_o) stalled_writes++;
            @(negedge clk);
        end
        xfer_en_i = 1'b1;
        chk(done_o, "R10 stalled copy completes", done_o, 1);
        chk(stalled_writes == 0, "R10 no write when disabled", stalled_writes, 0);
        for (int i = 0; i < 6; i++)
            chk(peek(16'h0700 + 16'(i)) == 8'h30 + 8'(i), "R10 stalled copy data", peek(16'h0700 + 16'(i)), 8'h30 + i);
    endtask

    task automatic t_start_ignored();
        int bc;
        for (int i = 0; i < 4; i++) poke(16'h0B00 + 16'(i), 8'hB0 + 8'(i));
        poke(16'h0E10, 8'h77);
        kick(1'b1, 16'h0C00, 8'd1, 16'd4, 16'h0B00);
        @(negedge clk);
        kick(1'b0, 16'h0D00, 8'd1, 16'd1, 16'h0000);
        wait_done(bc);
        for (int i = 0; i < 4; i++)
            chk(peek(16'h0C00 + 16'(i)) == 8'hB0 + 8'(i), "R11 copy unaffected", peek(16'h0C00 + 16'(i)), 8'hB0 + i);
        chk(!fill_armed_o && dst_o == 16'h0C04, "R11 no arm from busy start", dst_o, 16'h0C04);
        kick(1'b0, 16'h0E00, 8'd1, 16'd1, 16'h0000);
        kick(1'b1, 16'h0E10, 8'd1, 16'd1, 16'h0B00);
        chk(fill_armed_o && !busy_o, "R11 armed start ignored", {fill_armed_o, busy_o}, 2);
        data_write(16'h6655);
        wait_done(bc);
        chk(peek(16'h0E00) == 8'h66 && peek(16'h0E01) == 8'h66, "R11 fill kept", {peek(16'h0E00), peek(16'h0E01)}, 16'h6666);
        chk(peek(16'h0E10) == 8'h77, "R11 copy target untouched", peek(16'h0E10), 8'h77);
    endtask

    task automatic t_zero_len();
        int bc;
        kick(1'b0, 16'h0A00, 8'd0, 16'd0, 16'h0000);
        data_write(16'hC3A5);
        wait_done(bc);
        chk(bc == 65538, "R2 zero length busy cycles", bc, 65538);
        chk(len_o == 0 && dst_o == 16'h0A00, "R2 zero length writeback", dst_o, 16'h0A00);
        chk(peek(16'h0A00) == 8'hA5 && peek(16'h0A01) == 8'hC3, "R2 zero length data", {peek(16'h0A00), peek(16'h0A01)}, 16'hA5C3);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_copy_basic();
        t_copy_overlap();
        t_copy_wrap();
        t_fill_even();
        t_fill_odd();
        t_stall();
        t_start_ignored();
        t_zero_len();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule